// File: doc/BRIEF.md
# Set-Associative Cache Directory Lookup

This block is the address-translation directory of a four-way set-associative cache that sits in front of a 1 MB, byte-addressed main memory. The cache holds 32 KB in 16-byte blocks. A 20-bit main-memory address is loaded into an address register and split into four fields: a zone number, a group number, a block-within-group number and a byte offset. The group number selects one group of directory entries directly. Every way of that group is then compared by content at the same time against the tag, which is the zone number joined with the block-within-group number.

The outcome is combinational from the registered address. On a hit, the block reports the matching way and builds the 15-bit cache address from the group, the way and the offset. On a miss, it reports one of two cases. Either a free (invalid) way exists and the block names the lowest such way, or every way is occupied and a replacement is needed. A synchronous install port writes a tag into a chosen way and marks it valid. A global invalidate clears every valid bit. The data array, the victim choice and the memory interface belong to neighbouring blocks.

Top module: `setassoc_dir`

## Requirements
- R1: The registered address splits as follows. The zone is bits [19:15], the group is bits [14:6], the block-within-group is bits [5:4] and the offset is bits [3:0]. The lookup tag is {zone, block-within-group}, 7 bits.
- R2: When `addr_ld` is high, `addr_i` is captured on the rising clock edge, and all lookup outputs follow the new address in the cycle after that edge. When `addr_ld`, `ins_en` and `inv_all` are all low, the lookup outputs do not change.
- R3: After reset, every entry is invalid and the registered address is 0. So `hit`=0, `free_avail`=1, `free_way`=0 and `need_replace`=0.
- R4: `hit` is 1 when an entry in the selected group is valid and its stored tag equals the lookup tag. `hit_way` is that entry's way. If several ways match, `hit_way` is the lowest-numbered one.
- R5: `cache_addr` is {group, way, offset}, 15 bits. On a hit the way is `hit_way`; otherwise the way is `free_way`.
- R6: On a miss where at least one way of the group is invalid, `free_avail`=1 and `need_replace`=0. `free_way` is the lowest-numbered invalid way.
- R7: On a miss where all four ways of the group are valid, `need_replace`=1 and `free_avail`=0.
- R8: Exactly one of `hit`, `free_avail` and `need_replace` is 1 in every cycle.
- R9: When `ins_en` is high, `ins_tag` is stored into way `ins_way` of group `ins_group` on the rising edge, and that entry is marked valid. A lookup sees the entry from the next cycle on. A new install replaces the tag held there before.
- R10: When `inv_all` is high, all valid bits are cleared on the rising edge. When `inv_all` and `ins_en` are high in the same cycle, the invalidate wins and no entry is left valid.
- R11: An entry installed in one group never produces a hit for an address whose group field differs, even when the tags are equal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_ld | input | 1 | Load `addr_i` into the address register |
| addr_i | input | 20 | Main-memory byte address to look up |
| ins_en | input | 1 | Install a directory entry |
| ins_group | input | 9 | Group of the entry to install |
| ins_way | input | 2 | Way of the entry to install |
| ins_tag | input | 7 | Tag {zone, block-within-group} to store |
| inv_all | input | 1 | Clear every valid bit |
| hit | output | 1 | Lookup hit |
| hit_way | output | 2 | Way that matched |
| cache_addr | output | 15 | Cache byte address {group, way, offset} |
| free_avail | output | 1 | Miss with an invalid way available |
| free_way | output | 2 | Lowest-numbered invalid way in the group |
| need_replace | output | 1 | Miss with every way of the group valid |

## Verification
The assertions check four things on every cycle. Exactly one of hit, free-way and replace is reported. An install that targets the current group and tag yields a hit in the next cycle. An invalidate leaves no valid entry behind. The outputs hold still while no input acts on them. The bench's scenarios cover the rest: the field split of the address, the exact cache address assembled, the lowest-way choice among several matches or several free ways, overwriting an entry, keeping groups apart, and the invalidate winning over an install in the same cycle.

// File: rtl/setassoc_dir.sv
module setassoc_dir #(
  parameter int ADDR_W = 20,
  parameter int OFF_W  = 4,
  parameter int GRP_W  = 9,
  parameter int WAYS   = 4
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  addr_ld,
  input  logic [ADDR_W-1:0]                     addr_i,
  input  logic                                  ins_en,
  input  logic [GRP_W-1:0]                      ins_group,
  input  logic [$clog2(WAYS)-1:0]               ins_way,
  input  logic [ADDR_W-GRP_W-OFF_W-1:0]         ins_tag,
  input  logic                                  inv_all,
  output logic                                  hit,
  output logic [$clog2(WAYS)-1:0]               hit_way,
  output logic [GRP_W+$clog2(WAYS)+OFF_W-1:0]   cache_addr,
  output logic                                  free_avail,
  output logic [$clog2(WAYS)-1:0]               free_way,
  output logic                                  need_replace
);
  localparam int WAY_W  = $clog2(WAYS);
  localparam int TAG_W  = ADDR_W - GRP_W - OFF_W;
  localparam int ZONE_W = TAG_W - WAY_W;
  localparam int GROUPS = 1 << GRP_W;

  logic [ADDR_W-1:0] addr_q;
  logic [TAG_W-1:0]  tag_mem [GROUPS][WAYS];
  logic [WAYS-1:0]   vld [GROUPS];

  logic [GRP_W-1:0]  grp;
  logic [OFF_W-1:0]  off;
  logic [TAG_W-1:0]  tag;
  logic [WAYS-1:0]   match;
  logic [WAYS-1:0]   empty;
  logic              any_empty;

  assign off = addr_q[OFF_W-1:0];
  assign grp = addr_q[OFF_W+WAY_W +: GRP_W];
  assign tag = {addr_q[ADDR_W-1 -: ZONE_W], addr_q[OFF_W +: WAY_W]};

  always_ff @(posedge clk) begin
    if (!rst_n)
      addr_q <= '0;
    else if (addr_ld)
      addr_q <= addr_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || inv_all) begin
      for (int g = 0; g < GROUPS; g++) vld[g] <= '0;
    end else if (ins_en) begin
      vld[ins_group][ins_way] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (ins_en) tag_mem[ins_group][ins_way] <= ins_tag;
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign match[w] = vld[grp][w] && (tag_mem[grp][w] == tag);
    assign empty[w] = !vld[grp][w];
  end

  always_comb begin
    hit_way = '0;
    for (int w = WAYS - 1; w >= 0; w--)
      if (match[w]) hit_way = WAY_W'(w);
  end

  always_comb begin
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--)
      if (empty[w]) free_way = WAY_W'(w);
  end

  assign hit          = |match;
  assign any_empty    = |empty;
  assign free_avail   = !hit && any_empty;
  assign need_replace = !hit && !any_empty;
  assign cache_addr   = {grp, (hit ? hit_way : free_way), off};

  // R8
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({hit, free_avail, need_replace}) == 1);

  // R9
  install_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_en && !inv_all && !addr_ld && ins_group == grp && ins_tag == tag) |=> hit);

  // R10
  inv_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> (!hit && free_avail && free_way == '0));

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!addr_ld && !ins_en && !inv_all) |=>
      ($stable(cache_addr) && $stable(hit) && $stable(need_replace) && $stable(free_avail)));
endmodule

// File: tb/tb_setassoc_dir.sv
module tb_setassoc_dir;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        addr_ld = 0;
  logic [19:0] addr_i = '0;
  logic        ins_en = 0;
  logic [8:0]  ins_group = '0;
  logic [1:0]  ins_way = '0;
  logic [6:0]  ins_tag = '0;
  logic        inv_all = 0;
  logic        hit;
  logic [1:0]  hit_way;
  logic [14:0] cache_addr;
  logic        free_avail;
  logic [1:0]  free_way;
  logic        need_replace;

  int nchk = 0;
  int nfail = 0;

  setassoc_dir dut (
    .clk(clk), .rst_n(rst_n), .addr_ld(addr_ld), .addr_i(addr_i),
    .ins_en(ins_en), .ins_group(ins_group), .ins_way(ins_way), .ins_tag(ins_tag),
    .inv_all(inv_all), .hit(hit), .hit_way(hit_way), .cache_addr(cache_addr),
    .free_avail(free_avail), .free_way(free_way), .need_replace(need_replace)
  );

  always #5 clk = ~clk;

  function automatic logic [19:0] mk(input logic [4:0] z, input logic [8:0] g,
                                     input logic [1:0] b, input logic [3:0] o);
    return {z, g, b, o};
  endfunction

  function automatic logic [6:0] tg(input logic [4:0] z, input logic [1:0] b);
    return {z, b};
  endfunction

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input int got, input int exp);
    nchk++;
    if (got != exp) begin
      nfail++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic lookup(input logic [19:0] a);
    addr_i = a; addr_ld = 1; step(); addr_ld = 0;
  endtask

  task automatic install(input logic [8:0] g, input logic [1:0] w, input logic [6:0] t);
    ins_group = g; ins_way = w; ins_tag = t; ins_en = 1; step(); ins_en = 0;
  endtask

  task automatic expect_out(input string req, input int h, input int hw, input int fa,
                            input int fw, input int nr, input int ca);
    chk({req, " hit"}, hit, h);
    if (h) chk({req, " hit_way"}, hit_way, hw);
    chk({req, " free_avail"}, free_avail, fa);
    if (!h) chk({req, " free_way"}, free_way, fw);
    chk({req, " need_replace"}, need_replace, nr);
    chk({req, " cache_addr"}, cache_addr, ca);
  endtask

  task automatic t_reset();
    expect_out("R3 reset", 0, 0, 1, 0, 0, 0);
  endtask

  task automatic t_cold_and_hit();
    install(9'd5, 2'd0, tg(5'h13, 2'd2));
    lookup(mk(5'h13, 9'd5, 2'd2, 4'hA));
    expect_out("R4 R5 R1 hit way0", 1, 0, 0, 0, 0, {9'd5, 2'd0, 4'hA});
    lookup(mk(5'h13, 9'd5, 2'd1, 4'h3));
    expect_out("R6 cold miss", 0, 0, 1, 1, 0, {9'd5, 2'd1, 4'h3});
    lookup(mk(5'h12, 9'd5, 2'd2, 4'h3));
    expect_out("R1 zone differs", 0, 0, 1, 1, 0, {9'd5, 2'd1, 4'h3});
  endtask

  task automatic t_conflict();
    install(9'd5, 2'd1, tg(5'h01, 2'd0));
    install(9'd5, 2'd3, tg(5'h02, 2'd0));
    lookup(mk(5'h1F, 9'd5, 2'd3, 4'h0));
    expect_out("R6 lowest free way", 0, 0, 1, 2, 0, {9'd5, 2'd2, 4'h0});
    install(9'd5, 2'd2, tg(5'h03, 2'd1));
    expect_out("R7 conflict miss", 0, 0, 0, 0, 1, {9'd5, 2'd0, 4'h0});
    lookup(mk(5'h02, 9'd5, 2'd0, 4'hF));
    expect_out("R4 hit way3", 1, 3, 0, 0, 0, {9'd5, 2'd3, 4'hF});
  endtask

  task automatic t_dup_and_overwrite();
    install(9'd9, 2'd3, tg(5'h0A, 2'd3));
    install(9'd9, 2'd2, tg(5'h0A, 2'd3));
    lookup(mk(5'h0A, 9'd9, 2'd3, 4'h7));
    expect_out("R4 lowest match", 1, 2, 0, 0, 0, {9'd9, 2'd2, 4'h7});
    install(9'd9, 2'd2, tg(5'h0B, 2'd0));
    expect_out("R9 overwrite", 1, 3, 0, 0, 0, {9'd9, 2'd3, 4'h7});
  endtask

  task automatic t_groups();
    lookup(mk(5'h13, 9'd6, 2'd2, 4'hA));
    expect_out("R11 other group", 0, 0, 1, 0, 0, {9'd6, 2'd0, 4'hA});
    lookup(mk(5'h13, 9'h1FF, 2'd2, 4'h1));
    expect_out("R11 top group", 0, 0, 1, 0, 0, {9'h1FF, 2'd0, 4'h1});
    install(9'h1FF, 2'd1, tg(5'h13, 2'd2));
    expect_out("R9 install visible", 1, 1, 0, 0, 0, {9'h1FF, 2'd1, 4'h1});
  endtask

  task automatic t_hold();
    addr_i = mk(5'h00, 9'd5, 2'd0, 4'h0);
    step(); step();
    expect_out("R2 hold without load", 1, 1, 0, 0, 0, {9'h1FF, 2'd1, 4'h1});
  endtask

  task automatic t_inv();
    inv_all = 1; step(); inv_all = 0;
    expect_out("R10 invalidate", 0, 0, 1, 0, 0, {9'h1FF, 2'd0, 4'h1});
    lookup(mk(5'h02, 9'd5, 2'd0, 4'hF));
    expect_out("R10 group5 empty", 0, 0, 1, 0, 0, {9'd5, 2'd0, 4'hF});
    ins_group = 9'd5; ins_way = 2'd2; ins_tag = tg(5'h02, 2'd0);
    ins_en = 1; inv_all = 1; step(); ins_en = 0; inv_all = 0;
    expect_out("R10 inv beats install", 0, 0, 1, 0, 0, {9'd5, 2'd0, 4'hF});
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1;
    step();
    t_reset();
    t_cold_and_hit();
    t_conflict();
    t_dup_and_overwrite();
    t_groups();
    t_hold();
    t_inv();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule